// File: doc/BRIEF.md
# Programmable Duty-Cycle and Phase-Delay Clock Generator

This block is a fully digital model of a clock-shaping unit. It runs on an oversampling clock that is 32 times faster than the reference clock it models, so one reference period is 32 phase steps. It drives two outputs. The shaped clock has a programmable high time. The delayed clock is a 50% clock shifted by a programmable number of steps.

Software writes two 8-bit settings through a synchronous write port. The step setting gives a count N in 1/32 units. A 2-bit coarse field gives the quarter of the period, and one of two 3-bit fine fields adds the step inside that quarter. Which fine field is used depends on the coarse value. The control setting holds three bits:
- a loop-type bit, where 0 selects delay-line behaviour and 1 selects phase-lock behaviour;
- a feedback-source bit, which is only stored;
- a doubling bit, which gives a 2x output in delay-line behaviour.

A small state machine keeps the phase counter. It loads new settings only when the counter wraps, so the outputs never show a partial or glitch pulse.

The machine has three states:
- `ST_SYNC`: entered at reset. The outputs are low and the counter is held at 0.
- `ST_RUN_1X`: the counter steps through 32 phases.
- `ST_RUN_2X`: the counter steps through 16 phases.

It has three transitions:
- From `ST_SYNC`, the machine always leaves after one cycle, to `RUN_2X` or to `RUN_1X` depending on the settings.
- From either run state, a wrap with doubling selected and the loop-type bit at 0 goes to `ST_RUN_2X`.
- From either run state, any other wrap goes to `ST_RUN_1X`.

Between wraps the state does not change.

Top module: `clkshape_gen`

## Requirements
- R1: Address 0 (`wr_sel`/`rd_sel` = 0) is the step setting and reads back all 8 bits as written. Address 1 is the control setting: bit 0 is the loop type, bit 2 is the feedback source and bit 4 is doubling. Bits 1, 3, 5, 6 and 7 of address 1 always read 0.
- R2: After reset both settings read 0. The block runs in delay-line behaviour at 1x with N = 1: the shaped clock is high 1 of 32 steps.
- R3: The coarse field is bits [7:6] and N = 8*coarse + fine + 1. When coarse is 0 or 1, fine is bits [2:0] and bits [5:3] have no effect (0x7C gives N = 13). In 1x operation the shaped clock is high for the first N of every 32 steps.
- R4: When coarse is 2 or 3, fine is bits [5:3] and bits [2:0] have no effect (0xF3 gives N = 31). A sum of 32 (0xFF) is clamped to N = 31.
- R5: In 1x operation the delayed clock rises N steps after each rising edge of the shaped clock. It is high 16 of every 32 steps.
- R6: With doubling (control bit 4 = 1) and loop type 0, the period is 16 steps. Let H = max(1, floor(N/2)). The shaped clock is high H steps, and the delayed clock rises H steps after the shaped rise and is high 8 of 16 steps.
- R7: With loop type 1, the doubling bit has no effect: the outputs follow R3 to R5 at 32 steps. The feedback-source bit is stored and read back but does not change either output.
- R8: A setting written mid-period does not change the current period. The new setting takes effect from the period that starts at the next counter wrap.
- R9: While reset is asserted, and in the single `ST_SYNC` cycle after it, both output clocks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 32 ticks per reference period |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_sel | input | 1 | Write address: 0 = step setting, 1 = control setting |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read address, same encoding as `wr_sel` |
| rd_data | output | 8 | Combinational read data for `rd_sel` |
| clk_shaped | output | 1 | Clock with the programmed high time |
| clk_delayed | output | 1 | 50% clock delayed by the programmed step count |

## Verification
Read data is combinational and is due in the same cycle as `rd_sel`. A write lands at the next rising edge, but it reaches the outputs only at the first counter wrap after that edge. The outputs depend only on registered state, so they change one tick after each phase step. The bench waits at least two full periods after any setting change, then aligns to a rising edge of the shaped clock, which always marks phase 0. It samples every falling edge from there, so high time, delay offset and period are counted in whole steps. The mid-period update test writes one tick after phase 0 and expects the old high time for the rest of that period and the new one in the next.

// File: rtl/clkshape_pkg.sv
package clkshape_pkg;

    typedef enum logic [1:0] {
        ST_SYNC   = 2'd0,
        ST_RUN_1X = 2'd1,
        ST_RUN_2X = 2'd2
    } run_state_e;

    // Step count from the split coarse/fine encoding, clamped to 31.
    function automatic logic [4:0] calc_steps(input logic [7:0] setting);
        logic [1:0] coarse;
        logic [2:0] fine;
        logic [5:0] sum;
        coarse = setting[7:6];
        fine   = coarse[1] ? setting[5:3] : setting[2:0];
        sum    = {1'b0, coarse, 3'b000} + {3'b000, fine} + 6'd1;
        if (sum[5])
            return 5'd31;
        return sum[4:0];
    endfunction

endpackage

// File: rtl/clkshape_regs.sv
module clkshape_regs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] step_q,
    output logic             loop_sel_q,
    output logic             dbl_sel_q
);
    localparam int LOOP_BIT = 0;
    localparam int FB_BIT   = 2;
    localparam int DBL_BIT  = 4;

    logic fb_sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= '0;
            loop_sel_q <= 1'b0;
            fb_sel_q   <= 1'b0;
            dbl_sel_q  <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                step_q <= wr_data;
            end else begin
                loop_sel_q <= wr_data[LOOP_BIT];
                fb_sel_q   <= wr_data[FB_BIT];
                dbl_sel_q  <= wr_data[DBL_BIT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            rd_data = step_q;
        end else begin
            rd_data[LOOP_BIT] = loop_sel_q;
            rd_data[FB_BIT]   = fb_sel_q;
            rd_data[DBL_BIT]  = dbl_sel_q;
        end
    end

endmodule

// File: rtl/clkshape_phase_fsm.sv
module clkshape_phase_fsm
    import clkshape_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        step_q,
    input  logic              loop_sel_q,
    input  logic              dbl_sel_q,
    output run_state_e        state,
    output logic [STEP_W-1:0] phase,
    output logic [STEP_W-1:0] act_n,
    output logic              wrap
);
    localparam logic [STEP_W-1:0] LAST_FULL = {STEP_W{1'b1}};
    localparam logic [STEP_W-1:0] LAST_HALF = {1'b0, {(STEP_W-1){1'b1}}};

    run_state_e        state_nxt;
    logic              load;
    logic [STEP_W-1:0] last;

    assign last = (state == ST_RUN_2X) ? LAST_HALF : LAST_FULL;
    assign wrap = (state != ST_SYNC) && (phase == last);

    always_comb begin
        load      = 1'b0;
        state_nxt = state;
        unique case (state)
            ST_SYNC:   load = 1'b1;
            ST_RUN_1X: load = wrap;
            ST_RUN_2X: load = wrap;
            default:   load = 1'b1;
        endcase
        if (load)
            state_nxt = (!loop_sel_q && dbl_sel_q) ? ST_RUN_2X : ST_RUN_1X;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_SYNC;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            act_n <= STEP_W'(1);
        end else if (load) begin
            phase <= '0;
            act_n <= STEP_W'(calc_steps(step_q));
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/clkshape_outgen.sv
module clkshape_outgen
    import clkshape_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  run_state_e        state,
    input  logic [STEP_W-1:0] phase,
    input  logic [STEP_W-1:0] act_n,
    output logic              clk_shaped,
    output logic              clk_delayed
);
    logic [STEP_W-1:0] half_n;
    logic [STEP_W-1:0] diff_full;
    logic [STEP_W-2:0] diff_half;

    assign half_n    = ((act_n >> 1) == '0) ? STEP_W'(1) : (act_n >> 1);
    assign diff_full = phase - act_n;
    assign diff_half = phase[STEP_W-2:0] - half_n[STEP_W-2:0];

    always_comb begin
        clk_shaped  = 1'b0;
        clk_delayed = 1'b0;
        unique case (state)
            ST_SYNC: begin
                clk_shaped  = 1'b0;
                clk_delayed = 1'b0;
            end
            ST_RUN_1X: begin
                clk_shaped  = phase < act_n;
                clk_delayed = !diff_full[STEP_W-1];
            end
            ST_RUN_2X: begin
                clk_shaped  = phase < half_n;
                clk_delayed = !diff_half[STEP_W-2];
            end
            default: begin
                clk_shaped  = 1'b0;
                clk_delayed = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkshape_gen.sv
module clkshape_gen
    import clkshape_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int STEP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_shaped,
    output logic             clk_delayed
);
    logic [REG_W-1:0]  step_q;
    logic              loop_sel_q;
    logic              dbl_sel_q;
    run_state_e        state;
    logic [STEP_W-1:0] phase;
    logic [STEP_W-1:0] act_n;
    logic              wrap;

    clkshape_regs #(.REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .step_q     (step_q),
        .loop_sel_q (loop_sel_q),
        .dbl_sel_q  (dbl_sel_q)
    );

    clkshape_phase_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_q     (step_q[7:0]),
        .loop_sel_q (loop_sel_q),
        .dbl_sel_q  (dbl_sel_q),
        .state      (state),
        .phase      (phase),
        .act_n      (act_n),
        .wrap       (wrap)
    );

    clkshape_outgen #(.STEP_W(STEP_W)) u_out (
        .state       (state),
        .phase       (phase),
        .act_n       (act_n),
        .clk_shaped  (clk_shaped),
        .clk_delayed (clk_delayed)
    );

endmodule

// File: rtl/clkshape_chk.sv
module clkshape_chk
    import clkshape_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int STEP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input run_state_e        state,
    input logic [STEP_W-1:0] phase,
    input logic [STEP_W-1:0] act_n,
    input logic              wrap,
    input logic              rd_sel,
    input logic [REG_W-1:0]  rd_data,
    input logic              clk_shaped,
    input logic              clk_delayed
);
    localparam logic [STEP_W-1:0] HALF = STEP_W'(1 << (STEP_W - 1));
    localparam logic [REG_W-1:0]  RSV_MASK = REG_W'(8'hEA);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> ((rd_data & RSV_MASK) == '0));

    p_phase0_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SYNC && phase == '0) |-> clk_shaped);

    p_nonzero_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SYNC) |-> (act_n != '0));

    p_low_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> !clk_shaped);

    p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN_2X) |-> (phase < HALF));

    p_hold_until_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SYNC && !wrap) |=> ($stable(act_n) && $stable(state)));

    p_sync_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> (!clk_shaped && !clk_delayed));

endmodule

bind clkshape_gen clkshape_chk #(.REG_W(REG_W), .STEP_W(STEP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .phase       (phase),
    .act_n       (act_n),
    .wrap        (wrap),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .clk_shaped  (clk_shaped),
    .clk_delayed (clk_delayed)
);

// File: tb/sim_clkshape_gen.sv
module sim_clkshape_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       clk_shaped;
    logic       clk_delayed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkshape_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .clk_shaped(clk_shaped), .clk_delayed(clk_delayed)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input bit sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input bit sel, output logic [7:0] data);
        @(negedge clk);
        rd_sel = sel;
        #1;
        data = rd_data;
    endtask

    task automatic find_rise();
        bit prev;
        prev = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!prev && clk_shaped) return;
            prev = clk_shaped;
        end
    endtask

    // Aligns to phase 0 and measures one period.
    task automatic measure(input int per, input int hi, input int drise, input string tag);
        int  nhi, ndhi, rise_at;
        bit  pd;
        repeat (80) @(negedge clk);
        find_rise();
        nhi = 0; ndhi = 0; rise_at = -1;
        pd = clk_delayed;
        if (clk_shaped) nhi++;
        if (clk_delayed) ndhi++;
        for (int i = 1; i < per; i++) begin
            @(negedge clk);
            if (clk_shaped) nhi++;
            if (clk_delayed) ndhi++;
            if (!pd && clk_delayed && rise_at < 0) rise_at = i;
            pd = clk_delayed;
        end
        check(nhi == hi, {tag, " high time"}, nhi, hi);
        check(rise_at == drise, {tag, " delay offset R5"}, rise_at, drise);
        check(ndhi == per / 2, {tag, " delayed high R5"}, ndhi, per / 2);
        @(negedge clk);
        check(clk_shaped == 1'b1, {tag, " period"}, int'(clk_shaped), 1);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(!clk_shaped && !clk_delayed, "R9 outputs low in reset", int'({clk_shaped, clk_delayed}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        check(!clk_shaped && !clk_delayed, "R9 outputs low in sync cycle", int'({clk_shaped, clk_delayed}), 0);
        do_read(1'b0, d);
        check(d == 8'h00, "R2 step setting reset", d, 0);
        do_read(1'b1, d);
        check(d == 8'h00, "R2 control setting reset", d, 0);
        measure(32, 1, 1, "R2 default");
    endtask

    task automatic t_low_range();
        do_write(1'b0, 8'h7C);
        measure(32, 13, 13, "R3 0x7C");
        do_write(1'b0, 8'h07);
        measure(32, 8, 8, "R3 0x07");
        do_write(1'b0, 8'h3F);
        measure(32, 8, 8, "R3 0x3F bits5:3 ignored");
    endtask

    task automatic t_high_range();
        do_write(1'b0, 8'hF3);
        measure(32, 31, 31, "R4 0xF3");
        do_write(1'b0, 8'h97);
        measure(32, 19, 19, "R4 0x97 bits2:0 ignored");
        do_write(1'b0, 8'hFF);
        measure(32, 31, 31, "R4 clamp 0xFF");
    endtask

    task automatic t_double();
        do_write(1'b1, 8'h10);
        do_write(1'b0, 8'h7C);
        measure(16, 6, 6, "R6 2x N13");
        do_write(1'b0, 8'h00);
        measure(16, 1, 1, "R6 2x N1 min");
    endtask

    task automatic t_pll();
        logic [7:0] d;
        do_write(1'b0, 8'h7C);
        do_write(1'b1, 8'h11);
        measure(32, 13, 13, "R7 loop1 doubling ignored");
        do_write(1'b1, 8'h15);
        do_read(1'b1, d);
        check(d == 8'h15, "R7 feedback bit stored", d, 8'h15);
        measure(32, 13, 13, "R7 feedback bit no effect");
    endtask

    task automatic t_readback();
        logic [7:0] d;
        do_write(1'b1, 8'hFF);
        do_read(1'b1, d);
        check(d == 8'h15, "R1 reserved bits read 0", d, 8'h15);
        do_write(1'b0, 8'hA5);
        do_read(1'b0, d);
        check(d == 8'hA5, "R1 step setting readback", d, 8'hA5);
        do_write(1'b1, 8'h00);
    endtask

    task automatic t_wrap_update();
        int n0, n1;
        do_write(1'b0, 8'h03);
        repeat (80) @(negedge clk);
        find_rise();
        n0 = clk_shaped ? 1 : 0;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h98;
        for (int i = 1; i < 32; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (clk_shaped) n0++;
        end
        n1 = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (clk_shaped) n1++;
        end
        check(n0 == 4, "R8 current period keeps old N", n0, 4);
        check(n1 == 20, "R8 next period uses new N", n1, 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_low_range();
        t_high_range();
        t_readback();
        t_double();
        t_pll();
        do_write(1'b1, 8'h00);
        t_wrap_update();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule